// File: doc/BRIEF.md
# Effective-to-Physical Address Translator

This block turns a 32-bit effective address into a 32-bit physical address for either the instruction side or the data side of a core. Each side has its own fully associative page table cache of 4 KB pages and its own small array of block translation entries. Both structures are searched in the same cycle. A block-entry match overrides a page match. The low 12 address bits always pass through untranslated.

Each result carries a hit flag, a miss flag and a protection fault flag, along with the cache-inhibit attribute of the winning entry. Page entries also keep referenced and changed status. A page entry's protection comes from a per-privilege key bit and a two-bit page-protection field. A block entry has separate supervisor-valid and user-valid bits and a write-protect bit. Software loads entries through a write port. A page write whose tag is already present updates that entry in place. Otherwise the write fills a free slot, or evicts a round-robin victim when the side is full.

Top module: `at_translator`

## Requirements
- R1: A request on `req_valid` gives its result one clock later, with `res_valid` high for exactly that one cycle. With no request, `res_valid` stays low.
- R2: A page hit needs a valid entry on the selected side (`req_inst`=1 instruction, 0 data) whose 20-bit tag equals EA[31:12]. It yields PA = {entry page number, EA[11:0]}. The two sides never see each other's entries.
- R3: Block entry j matches when its privilege-valid bit is set (user-valid if `req_user`, else supervisor-valid) and ((EA[31:12] xor base) and not mask) is zero. PA[31:12] = (rpn and not mask) or (EA[31:12] and mask). The lowest matching index wins.
- R4: When a block entry and a page entry both match, the block translation is used and `res_bat`=1. The page entry's referenced and changed bits are left untouched, and `res_ref`/`res_chg` read 0.
- R5: If neither structure matches, `res_miss`=1, and `res_hit`, `res_fault`, `res_ci` and `res_pa` are all 0.
- R6: A page access uses key = `req_user` ? user key : supervisor key. Key 0 allows everything. With key 1, protection field 00 denies all accesses, 01 and 11 allow loads only, and 10 allows loads and stores. A denied access gives `res_hit`=1 and `res_fault`=1.
- R7: A store that matches a block entry with write-protect set faults. Loads through that entry never fault.
- R8: `res_ref`/`res_chg` show the page entry's bits as they were before the access. A page-translated hit sets referenced. A page-translated store that does not fault also sets changed.
- R9: A page write whose tag matches a valid entry on that side replaces that entry in place and clears its referenced and changed bits. With `wr_valid`=0 the write invalidates the entry. An invalidating write with no matching tag changes nothing.
- R10: A page write with a new tag takes the lowest-numbered free slot. When all slots are valid, it takes the slot under a round-robin pointer. That pointer starts at 0 after reset and advances by one, wrapping, only on such an eviction.
- R11: `res_ci` reports the cache-inhibit bit of the entry that supplied the translation.
- R12: After reset, every page and block entry is invalid and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_ea | input | 32 | Effective address |
| req_user | input | 1 | 1 = user privilege, 0 = supervisor |
| req_store | input | 1 | 1 = store, 0 = load |
| req_inst | input | 1 | 1 = instruction side, 0 = data side |
| res_valid | output | 1 | Result strobe, one cycle after the request |
| res_pa | output | 32 | Physical address |
| res_hit | output | 1 | A translation was found |
| res_bat | output | 1 | Translation came from a block entry |
| res_miss | output | 1 | Neither structure matched |
| res_fault | output | 1 | Protection violation |
| res_ci | output | 1 | Cache-inhibit attribute |
| res_ref | output | 1 | Page referenced bit before the access |
| res_chg | output | 1 | Page changed bit before the access |
| wr_en | input | 1 | Entry write strobe |
| wr_bat | input | 1 | 1 = write a block entry, 0 = write a page entry |
| wr_inst | input | 1 | Side to write: 1 instruction, 0 data |
| wr_idx | input | 2 | Block entry index |
| wr_valid | input | 1 | Page entry valid (0 invalidates the matching tag) |
| wr_tag | input | 20 | Page tag or block base |
| wr_rpn | input | 20 | Physical page number or block physical base |
| wr_mask | input | 20 | Block size mask (1 = bit taken from the address) |
| wr_pp | input | 2 | Page protection field |
| wr_ks | input | 1 | Page supervisor key |
| wr_ku | input | 1 | Page user key |
| wr_ci | input | 1 | Cache-inhibit attribute |
| wr_vs | input | 1 | Block supervisor-valid |
| wr_vu | input | 1 | Block user-valid |
| wr_wp | input | 1 | Block write-protect |

## Verification
Some properties are checked on every cycle. These are the one-cycle result timing, the untranslated offset on every hit, the exclusiveness of miss against hit and fault, and the rule that a fault always comes with a hit. Also checked every cycle: block results never report page status, no two page entries on a side ever match one address, and no entry is ever marked changed without being marked referenced. Other behaviour shows only in the bench's access sequences. This covers referenced/changed history over several accesses, in-place rewrites, round-robin eviction order once a side is full, block-over-page priority, and each protection encoding under both privileges.

// File: rtl/at_pkg.sv
package at_pkg;
  parameter int EA_W  = 32;
  parameter int OFF_W = 12;
  localparam int PN_W = EA_W - OFF_W;

  typedef struct packed {
    logic [PN_W-1:0] tag;
    logic [PN_W-1:0] ppn;
    logic [1:0]      pp;
    logic            ks;
    logic            ku;
    logic            ci;
  } pte_t;

  typedef struct packed {
    logic            vs;
    logic            vu;
    logic [PN_W-1:0] base;
    logic [PN_W-1:0] mask;
    logic [PN_W-1:0] rpn;
    logic            wp;
    logic            ci;
  } bat_t;
endpackage

// File: rtl/at_page_tlb.sv
module at_page_tlb
  import at_pkg::*;
#(
  parameter int ENTRIES = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PN_W-1:0] lk_vpn,
  output logic            lk_hit,
  output pte_t            lk_pte,
  output logic            lk_ref,
  output logic            lk_chg,
  input  logic            upd_en,
  input  logic            upd_chg,
  input  logic            wr_en,
  input  logic            wr_valid,
  input  pte_t            wr_pte
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  pte_t             ent_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q, ref_q, chg_q;
  logic [IW-1:0]    rr_q;

  logic [ENTRIES-1:0] hit_vec, wmatch_vec;
  logic [IW-1:0]    lk_idx, m_idx, f_idx, w_idx;
  logic             w_match, w_free, w_do, w_repl;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign hit_vec[i]    = vld_q[i] && (ent_q[i].tag == lk_vpn);
    assign wmatch_vec[i] = vld_q[i] && (ent_q[i].tag == wr_pte.tag);
  end

  always_comb begin
    lk_hit = 1'b0;
    lk_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        lk_hit = 1'b1;
        lk_idx = IW'(i);
      end
    end
  end

  assign lk_pte = ent_q[lk_idx];
  assign lk_ref = ref_q[lk_idx];
  assign lk_chg = chg_q[lk_idx];

  always_comb begin
    w_match = 1'b0;
    w_free  = 1'b0;
    m_idx   = '0;
    f_idx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (wmatch_vec[i]) begin
        w_match = 1'b1;
        m_idx   = IW'(i);
      end
      if (!vld_q[i]) begin
        w_free = 1'b1;
        f_idx  = IW'(i);
      end
    end
    w_idx  = w_match ? m_idx : (w_free ? f_idx : rr_q);
    w_do   = wr_en && (w_match || wr_valid);
    w_repl = w_do && !w_match && !w_free;
  end

  // Entry payload: written without reset so it can map to distributed RAM.
  always_ff @(posedge clk) begin
    if (w_do) ent_q[w_idx] <= wr_pte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      ref_q <= '0;
      chg_q <= '0;
      rr_q  <= '0;
    end else begin
      if (upd_en && lk_hit) begin
        ref_q[lk_idx] <= 1'b1;
        if (upd_chg) chg_q[lk_idx] <= 1'b1;
      end
      if (w_do) begin
        vld_q[w_idx] <= wr_valid;
        ref_q[w_idx] <= 1'b0;
        chg_q[w_idx] <= 1'b0;
      end
      if (w_repl) rr_q <= (rr_q == IW'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  assert_single_hit_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));
  assert_chg_implies_ref_R8: assert property (@(posedge clk) disable iff (rst)
    (chg_q & ~ref_q) == '0);
endmodule

// File: rtl/at_bat_array.sv
module at_bat_array
  import at_pkg::*;
#(
  parameter int ENTRIES = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [PN_W-1:0]            lk_vpn,
  input  logic                       lk_user,
  output logic                       lk_hit,
  output logic [PN_W-1:0]            lk_rpn,
  output logic                       lk_wp,
  output logic                       lk_ci,
  input  logic                       wr_en,
  input  logic [$clog2(ENTRIES)-1:0] wr_idx,
  input  bat_t                       wr_bat
);
  bat_t             bat_q [ENTRIES];
  logic [ENTRIES-1:0] match_vec;
  logic [PN_W-1:0]  sel_mask;

  for (genvar j = 0; j < ENTRIES; j++) begin : g_match
    assign match_vec[j] = (lk_user ? bat_q[j].vu : bat_q[j].vs) &&
                          (((lk_vpn ^ bat_q[j].base) & ~bat_q[j].mask) == '0);
  end

  always_comb begin
    lk_hit   = 1'b0;
    lk_rpn   = '0;
    lk_wp    = 1'b0;
    lk_ci    = 1'b0;
    sel_mask = '0;
    for (int j = ENTRIES - 1; j >= 0; j--) begin
      if (match_vec[j]) begin
        lk_hit   = 1'b1;
        sel_mask = bat_q[j].mask;
        lk_rpn   = (bat_q[j].rpn & ~bat_q[j].mask) | (lk_vpn & bat_q[j].mask);
        lk_wp    = bat_q[j].wp;
        lk_ci    = bat_q[j].ci;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < ENTRIES; j++) begin
        bat_q[j].vs <= 1'b0;
        bat_q[j].vu <= 1'b0;
      end
    end else if (wr_en) begin
      bat_q[wr_idx] <= wr_bat;
    end
  end

  assert_block_passthrough_R3: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> (((lk_rpn ^ lk_vpn) & sel_mask) == '0));
endmodule

// File: rtl/at_translator.sv
module at_translator
  import at_pkg::*;
#(
  parameter int TLB_ENTRIES = 64,
  parameter int BAT_ENTRIES = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           req_valid,
  input  logic [31:0]                    req_ea,
  input  logic                           req_user,
  input  logic                           req_store,
  input  logic                           req_inst,
  output logic                           res_valid,
  output logic [31:0]                    res_pa,
  output logic                           res_hit,
  output logic                           res_bat,
  output logic                           res_miss,
  output logic                           res_fault,
  output logic                           res_ci,
  output logic                           res_ref,
  output logic                           res_chg,
  input  logic                           wr_en,
  input  logic                           wr_bat,
  input  logic                           wr_inst,
  input  logic [$clog2(BAT_ENTRIES)-1:0] wr_idx,
  input  logic                           wr_valid,
  input  logic [19:0]                    wr_tag,
  input  logic [19:0]                    wr_rpn,
  input  logic [19:0]                    wr_mask,
  input  logic [1:0]                     wr_pp,
  input  logic                           wr_ks,
  input  logic                           wr_ku,
  input  logic                           wr_ci,
  input  logic                           wr_vs,
  input  logic                           wr_vu,
  input  logic                           wr_wp
);
  localparam int SIDES = 2;  // index 0 instruction, 1 data

  pte_t            wr_pte;
  bat_t            wr_blk;
  logic [PN_W-1:0] vpn;

  logic            t_hit [SIDES];
  pte_t            t_pte [SIDES];
  logic            t_ref [SIDES];
  logic            t_chg [SIDES];
  logic            b_hit [SIDES];
  logic [PN_W-1:0] b_rpn [SIDES];
  logic            b_wp  [SIDES];
  logic            b_ci  [SIDES];
  logic            page_ok;

  assign vpn = req_ea[EA_W-1:OFF_W];
  assign wr_pte = '{tag: wr_tag, ppn: wr_rpn, pp: wr_pp, ks: wr_ks, ku: wr_ku, ci: wr_ci};
  assign wr_blk = '{vs: wr_vs, vu: wr_vu, base: wr_tag, mask: wr_mask, rpn: wr_rpn,
                    wp: wr_wp, ci: wr_ci};

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    localparam bit IS_INST = (s == 0);
    logic side_req;
    assign side_req = req_valid && (req_inst == IS_INST);

    at_page_tlb #(.ENTRIES(TLB_ENTRIES)) i_tlb (
      .clk     (clk),
      .rst     (rst),
      .lk_vpn  (vpn),
      .lk_hit  (t_hit[s]),
      .lk_pte  (t_pte[s]),
      .lk_ref  (t_ref[s]),
      .lk_chg  (t_chg[s]),
      .upd_en  (side_req && !b_hit[s]),
      .upd_chg (req_store && page_ok),
      .wr_en   (wr_en && !wr_bat && (wr_inst == IS_INST)),
      .wr_valid(wr_valid),
      .wr_pte  (wr_pte)
    );

    at_bat_array #(.ENTRIES(BAT_ENTRIES)) i_bat (
      .clk    (clk),
      .rst    (rst),
      .lk_vpn (vpn),
      .lk_user(req_user),
      .lk_hit (b_hit[s]),
      .lk_rpn (b_rpn[s]),
      .lk_wp  (b_wp[s]),
      .lk_ci  (b_ci[s]),
      .wr_en  (wr_en && wr_bat && (wr_inst == IS_INST)),
      .wr_idx (wr_idx),
      .wr_bat (wr_blk)
    );
  end

  // Side selection and result formation
  logic            s_thit, s_bhit, s_bwp, s_bci, s_ref, s_chg, key;
  pte_t            s_pte;
  logic [PN_W-1:0] s_brpn;
  logic            n_hit, n_bat, n_fault, n_ci, n_ref, n_chg;
  logic [31:0]     n_pa;

  always_comb begin
    s_thit = req_inst ? t_hit[0] : t_hit[1];
    s_pte  = req_inst ? t_pte[0] : t_pte[1];
    s_ref  = req_inst ? t_ref[0] : t_ref[1];
    s_chg  = req_inst ? t_chg[0] : t_chg[1];
    s_bhit = req_inst ? b_hit[0] : b_hit[1];
    s_brpn = req_inst ? b_rpn[0] : b_rpn[1];
    s_bwp  = req_inst ? b_wp[0]  : b_wp[1];
    s_bci  = req_inst ? b_ci[0]  : b_ci[1];

    key     = req_user ? s_pte.ku : s_pte.ks;
    page_ok = !key || (s_pte.pp == 2'b10) || (s_pte.pp[0] && !req_store);

    n_hit = 1'b0; n_bat = 1'b0; n_fault = 1'b0; n_ci = 1'b0;
    n_ref = 1'b0; n_chg = 1'b0; n_pa = '0;
    if (s_bhit) begin
      n_hit   = 1'b1;
      n_bat   = 1'b1;
      n_pa    = {s_brpn, req_ea[OFF_W-1:0]};
      n_fault = req_store && s_bwp;
      n_ci    = s_bci;
    end else if (s_thit) begin
      n_hit   = 1'b1;
      n_pa    = {s_pte.ppn, req_ea[OFF_W-1:0]};
      n_fault = !page_ok;
      n_ci    = s_pte.ci;
      n_ref   = s_ref;
      n_chg   = s_chg;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0; res_pa <= '0; res_hit <= 1'b0; res_bat <= 1'b0;
      res_miss <= 1'b0; res_fault <= 1'b0; res_ci <= 1'b0;
      res_ref <= 1'b0; res_chg <= 1'b0;
    end else begin
      res_valid <= req_valid;
      res_pa    <= req_valid ? n_pa : '0;
      res_hit   <= req_valid && n_hit;
      res_bat   <= req_valid && n_bat;
      res_miss  <= req_valid && !n_hit;
      res_fault <= req_valid && n_fault;
      res_ci    <= req_valid && n_ci;
      res_ref   <= req_valid && n_ref;
      res_chg   <= req_valid && n_chg;
    end
  end

  assert_result_latency_R1: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> res_valid);
  assert_no_spurious_result_R1: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !res_valid);
  assert_offset_passthrough_R2: assert property (@(posedge clk) disable iff (rst)
    res_hit |-> (res_pa[OFF_W-1:0] == $past(req_ea[OFF_W-1:0])));
  assert_miss_clean_R5: assert property (@(posedge clk) disable iff (rst)
    res_miss |-> (!res_hit && !res_fault && !res_ci && res_pa == '0));
  assert_fault_needs_hit_R6: assert property (@(posedge clk) disable iff (rst)
    res_fault |-> res_hit);
  assert_block_no_status_R4: assert property (@(posedge clk) disable iff (rst)
    res_bat |-> (res_hit && !res_ref && !res_chg));
endmodule

// File: tb/test_at_translator.sv
module test_at_translator;
  localparam int N  = 64;
  localparam int NB = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic        req_valid = 0, req_user = 0, req_store = 0, req_inst = 0;
  logic [31:0] req_ea = '0;
  logic        res_valid, res_hit, res_bat, res_miss, res_fault, res_ci, res_ref, res_chg;
  logic [31:0] res_pa;
  logic        wr_en = 0, wr_bat = 0, wr_inst = 0, wr_valid = 0;
  logic [1:0]  wr_idx = '0, wr_pp = '0;
  logic [19:0] wr_tag = '0, wr_rpn = '0, wr_mask = '0;
  logic        wr_ks = 0, wr_ku = 0, wr_ci = 0, wr_vs = 0, wr_vu = 0, wr_wp = 0;

  at_translator i_at_translator (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ea(req_ea), .req_user(req_user),
    .req_store(req_store), .req_inst(req_inst), .res_valid(res_valid), .res_pa(res_pa),
    .res_hit(res_hit), .res_bat(res_bat), .res_miss(res_miss), .res_fault(res_fault),
    .res_ci(res_ci), .res_ref(res_ref), .res_chg(res_chg), .wr_en(wr_en), .wr_bat(wr_bat),
    .wr_inst(wr_inst), .wr_idx(wr_idx), .wr_valid(wr_valid), .wr_tag(wr_tag),
    .wr_rpn(wr_rpn), .wr_mask(wr_mask), .wr_pp(wr_pp), .wr_ks(wr_ks), .wr_ku(wr_ku),
    .wr_ci(wr_ci), .wr_vs(wr_vs), .wr_vu(wr_vu), .wr_wp(wr_wp)
  );

  int n_chk = 0, n_bad = 0;

  // Reference state: side 0 instruction, side 1 data
  logic        m_vld [2][N];
  logic [19:0] m_tag [2][N], m_ppn [2][N];
  logic [1:0]  m_pp  [2][N];
  logic        m_ks [2][N], m_ku [2][N], m_ci [2][N], m_ref [2][N], m_chg [2][N];
  int          m_rr [2];
  logic        b_vs [2][NB], b_vu [2][NB], b_wp [2][NB], b_ci [2][NB];
  logic [19:0] b_base [2][NB], b_mask [2][NB], b_rpn [2][NB];

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void model_reset();
    for (int s = 0; s < 2; s++) begin
      m_rr[s] = 0;
      for (int i = 0; i < N; i++) begin
        m_vld[s][i] = 0; m_ref[s][i] = 0; m_chg[s][i] = 0;
      end
      for (int j = 0; j < NB; j++) begin
        b_vs[s][j] = 0; b_vu[s][j] = 0;
      end
    end
  endfunction

  function automatic void model_wtlb(int s, logic v, logic [19:0] tag, logic [19:0] ppn,
                                     logic [1:0] pp, logic ks, logic ku, logic ci);
    int idx = -1;
    for (int i = 0; i < N; i++) if (idx < 0 && m_vld[s][i] && m_tag[s][i] == tag) idx = i;
    if (idx < 0) begin
      if (!v) return;
      for (int i = 0; i < N; i++) if (idx < 0 && !m_vld[s][i]) idx = i;
      if (idx < 0) begin
        idx = m_rr[s];
        m_rr[s] = (m_rr[s] + 1) % N;
      end
    end
    m_vld[s][idx] = v; m_tag[s][idx] = tag; m_ppn[s][idx] = ppn; m_pp[s][idx] = pp;
    m_ks[s][idx] = ks; m_ku[s][idx] = ku; m_ci[s][idx] = ci;
    m_ref[s][idx] = 0; m_chg[s][idx] = 0;
  endfunction

  // Returns {valid,hit,bat,miss,fault,ci,ref,chg,pa}
  function automatic logic [39:0] model_acc(logic [31:0] ea, logic user, logic st, logic inst);
    int s = inst ? 0 : 1;
    logic [19:0] vpn = ea[31:12];
    logic key, ok;
    for (int j = 0; j < NB; j++)
      if ((user ? b_vu[s][j] : b_vs[s][j]) && (((vpn ^ b_base[s][j]) & ~b_mask[s][j]) == 0))
        return {1'b1, 1'b1, 1'b1, 1'b0, st & b_wp[s][j], b_ci[s][j], 2'b00,
                (b_rpn[s][j] & ~b_mask[s][j]) | (vpn & b_mask[s][j]), ea[11:0]};
    for (int i = 0; i < N; i++)
      if (m_vld[s][i] && m_tag[s][i] == vpn) begin
        logic [39:0] r;
        key = user ? m_ku[s][i] : m_ks[s][i];
        ok  = !key || m_pp[s][i] == 2'b10 || (m_pp[s][i][0] && !st);
        r = {1'b1, 1'b1, 1'b0, 1'b0, !ok, m_ci[s][i], m_ref[s][i], m_chg[s][i],
             m_ppn[s][i], ea[11:0]};
        m_ref[s][i] = 1;
        if (st && ok) m_chg[s][i] = 1;
        return r;
      end
    return {1'b1, 1'b0, 1'b0, 1'b1, 36'd0};
  endfunction

  task automatic wtlb(logic inst, logic v, logic [19:0] tag, logic [19:0] ppn,
                      logic [1:0] pp, logic ks, logic ku, logic ci);
    @(negedge clk);
    wr_en = 1; wr_bat = 0; wr_inst = inst; wr_valid = v; wr_tag = tag; wr_rpn = ppn;
    wr_pp = pp; wr_ks = ks; wr_ku = ku; wr_ci = ci;
    model_wtlb(inst ? 0 : 1, v, tag, ppn, pp, ks, ku, ci);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wbat(logic inst, int j, logic vs, logic vu, logic [19:0] base,
                      logic [19:0] mask, logic [19:0] rpn, logic wp, logic ci);
    int s = inst ? 0 : 1;
    @(negedge clk);
    wr_en = 1; wr_bat = 1; wr_inst = inst; wr_idx = 2'(j); wr_vs = vs; wr_vu = vu;
    wr_tag = base; wr_mask = mask; wr_rpn = rpn; wr_wp = wp; wr_ci = ci;
    b_vs[s][j] = vs; b_vu[s][j] = vu; b_base[s][j] = base; b_mask[s][j] = mask;
    b_rpn[s][j] = rpn; b_wp[s][j] = wp; b_ci[s][j] = ci;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic acc(string req, logic [31:0] ea, logic user, logic st, logic inst);
    logic [39:0] exp;
    @(negedge clk);
    req_valid = 1; req_ea = ea; req_user = user; req_store = st; req_inst = inst;
    exp = model_acc(ea, user, st, inst);
    @(negedge clk);
    req_valid = 0;
    check(req, 64'({res_valid, res_hit, res_bat, res_miss, res_fault, res_ci,
                    res_ref, res_chg, res_pa}), 64'(exp));
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    // R12: reset state at the outputs, then an empty lookup misses
    check("R12", 64'({res_valid, res_hit, res_bat, res_miss, res_fault, res_ci,
                      res_ref, res_chg, res_pa}), 64'd0);
    acc("R12", 32'h12345678, 0, 0, 0);
    acc("R5", 32'h0000_0fff, 1, 1, 1);
    @(negedge clk);
    check("R1", 64'(res_valid), 64'd0);

    // R2: data-side page translation, instruction side unaffected
    wtlb(0, 1, 20'h12345, 20'hABCDE, 2'b10, 0, 0, 0);
    acc("R2", 32'h12345678, 0, 0, 0);
    check("R2", 64'(res_pa), 64'hABCDE678);
    acc("R2", 32'h12345678, 0, 0, 1);
    check("R2", 64'(res_miss), 64'd1);

    // R8: status history over load, store, load
    acc("R8", 32'h12345004, 0, 1, 0);
    acc("R8", 32'h12345008, 0, 0, 0);
    check("R8", 64'({res_ref, res_chg}), 64'b11);

    // R6: protection encodings
    wtlb(0, 1, 20'h22000, 20'h33000, 2'b01, 0, 1, 0);
    acc("R6", 32'h22000010, 1, 1, 0);
    check("R6", 64'(res_fault), 64'd1);
    acc("R6", 32'h22000010, 1, 0, 0);
    acc("R6", 32'h22000010, 0, 1, 0);
    acc("R8", 32'h22000010, 0, 0, 0);
    wtlb(0, 1, 20'h22001, 20'h33001, 2'b00, 1, 1, 1);
    acc("R6", 32'h22001000, 0, 0, 0);
    acc("R11", 32'h22001000, 0, 0, 0);
    wtlb(0, 1, 20'h22002, 20'h33002, 2'b11, 1, 1, 0);
    acc("R6", 32'h22002000, 1, 0, 0);
    acc("R6", 32'h22002000, 1, 1, 0);

    // R3 / R7 / R11: block translation, supervisor only, write-protected
    wbat(0, 1, 1, 0, 20'h10000, 20'h000FF, 20'h20000, 1, 1);
    acc("R3", 32'h10042abc, 0, 0, 0);
    check("R3", 64'(res_pa), 64'h20042abc);
    acc("R3", 32'h10042abc, 1, 0, 0);
    acc("R7", 32'h100ff000, 0, 1, 0);
    check("R7", 64'(res_fault), 64'd1);
    // lower index wins over index 1
    wbat(0, 0, 1, 1, 20'h10040, 20'h0000F, 20'h30000, 0, 0);
    acc("R3", 32'h10042abc, 0, 1, 0);
    check("R3", 64'(res_pa), 64'h30002abc);

    // R4: block overrides a page entry and leaves its status alone
    wtlb(0, 1, 20'h10080, 20'h55555, 2'b10, 0, 0, 0);
    acc("R4", 32'h10080123, 0, 1, 0);
    check("R4", 64'(res_bat), 64'd1);
    wbat(0, 1, 0, 0, 20'h10000, 20'h000FF, 20'h20000, 1, 1);
    acc("R4", 32'h10080123, 0, 0, 0);
    check("R4", 64'({res_bat, res_ref, res_chg}), 64'd0);

    // R9: in-place rewrite and invalidation
    wtlb(0, 1, 20'h12345, 20'h0F0F0, 2'b10, 0, 0, 1);
    acc("R9", 32'h12345abc, 0, 0, 0);
    check("R9", 64'({res_ref, res_pa}), 64'h0F0F0abc);
    wtlb(0, 0, 20'h77777, 20'h0, 2'b00, 0, 0, 0);
    acc("R9", 32'h22000000, 0, 0, 0);
    wtlb(0, 0, 20'h12345, 20'h0, 2'b00, 0, 0, 0);
    acc("R9", 32'h12345abc, 0, 0, 0);
    check("R9", 64'(res_miss), 64'd1);

    // R10: fill the instruction side, then evict in round-robin order
    for (int i = 0; i < N; i++) wtlb(1, 1, 20'h40000 + 20'(i), 20'h60000 + 20'(i), 2'b10, 0, 0, 0);
    acc("R10", 32'h4003f000, 0, 0, 1);
    wtlb(1, 1, 20'h50000, 20'h70000, 2'b10, 0, 0, 0);
    acc("R10", 32'h40000000, 0, 0, 1);
    check("R10", 64'(res_miss), 64'd1);
    acc("R10", 32'h40001000, 0, 0, 1);
    acc("R10", 32'h50000000, 0, 0, 1);
    wtlb(1, 1, 20'h50001, 20'h70001, 2'b10, 0, 0, 0);
    acc("R10", 32'h40001000, 0, 0, 1);
    check("R10", 64'(res_miss), 64'd1);
    acc("R10", 32'h40002000, 0, 0, 1);

    // Random mix against the reference functions
    for (int k = 0; k < 1500; k++) begin
      int r = int'($urandom % 10);
      logic [19:0] t = 20'h00100 + 20'($urandom % 96);
      logic inst = 1'($urandom);
      if (r < 2) begin
        wtlb(inst, ($urandom % 8) != 0, t, 20'($urandom), 2'($urandom), 1'($urandom),
             1'($urandom), 1'($urandom));
      end else if (r == 2) begin
        wbat(inst, int'($urandom % NB), 1'($urandom), 1'($urandom),
             20'h00100 + 20'($urandom % 96), 20'($urandom % 4) * 20'h5,
             20'($urandom), 1'($urandom), 1'($urandom));
      end else begin
        logic [39:0] e;
        acc("R2", {t, 12'($urandom)}, 1'($urandom), 1'($urandom), inst);
      end
    end

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule